// File: doc/BRIEF.md
# Predicated Integer-to-Condition-Field Vector Writer

This block walks a vector of consecutive 4-bit condition fields and writes each one from a single bit of a 64-bit integer source. The mask, mode and merge controls are shared by every element. A 64-bit integer predicate gates each element, and the predicate can optionally be inverted. When zeroing is enabled, an element whose predicate bit is off has its field written as all zeros. When zeroing is disabled, that field is left alone. Set the zero-source flag to treat the integer source as zero. This matches an operation that names the zero register, so the integer source is not read.

A `start` pulse in the idle state captures every operand. The sequencer then handles one element per clock, starting at the base field and counting up, and wraps modulo the number of fields. When merge is set, the block reads the destination field through a combinational read port that shares the write index, and keeps the bits that the mask leaves out. When the vector is finished, the block pulses `done` for one cycle and returns to idle.

The block has three states. IDLE waits for start. On start it takes the transition "launch" to RUN, or "empty" straight to DONE when the vector length is zero. RUN handles one element per cycle. It stays in RUN with the transition "step" and leaves after the last element with "finish" to DONE. DONE raises `done` for one cycle and takes the transition "retire" back to IDLE.

Top module: `pvec_field_writer`

## Requirements
- R1: After reset the block is idle: `wr_en`, `done` and `busy` are all 0.
- R2: Element i of a run uses predicate bit i and source bit i. It targets field (base + i) modulo NUM_FIELDS. Elements are handled in ascending order, one per clock, starting the cycle after the start edge.
- R3: If the effective predicate bit of an element is 0 and zeroing is on, the element writes 4'b0000 whatever the source, mask, mode or merge inputs are.
- R4: If the effective predicate bit is 0 and zeroing is off, no write is issued and that field keeps its value.
- R5: For an active element with source bit s, each bit k of the written value is mask[k] AND (mode[k] == s). This gives mask AND NOT mode when s=0 and mask AND mode when s=1. For example, mask 0011 with mode 0000 and s=0 writes 0011.
- R6: When `src_zero` is 1, every element uses source bit 0 whatever `src` holds.
- R7: For an active element with merge=1, every bit whose mask bit is 0 takes its value from `rd_data`, read at the written index. With merge=0 those bits are written as 0.
- R8: When `pred_inv` is 1, the effective predicate bit is the inverse of the predicate register bit.
- R9: `done` is high for exactly one cycle, in the cycle after the last element. `busy` is high from the cycle after the start edge through the `done` cycle. A `start` while busy is ignored.
- R10: A vector length of 0 issues no write and raises `done` in the cycle after the start edge.
- R11: A vector length above MAX_VL is handled as MAX_VL elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a run; sampled only when idle |
| base_idx | input | IDX_W | First destination field |
| vlen | input | VL_W | Number of elements |
| pred | input | 64 | Destination predicate, bit i gates element i |
| pred_inv | input | 1 | Invert the predicate |
| zero_en | input | 1 | Zeroing of predicated-off elements |
| src | input | 64 | Integer source, bit i feeds element i |
| src_zero | input | 1 | Treat source as zero |
| mask | input | 4 | Per-bit mask |
| mode | input | 4 | Per-bit mode |
| merge | input | 1 | Keep unmasked destination bits |
| rd_idx | output | IDX_W | Field read address (equals wr_idx) |
| rd_data | input | 4 | Current value of the addressed field |
| wr_en | output | 1 | Field write strobe |
| wr_idx | output | IDX_W | Field write address |
| wr_data | output | 4 | Field write value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check properties that must hold on every cycle. The write index steps by one on each clock within a run. A zeroed element carries all-zero data. Merged writes keep the unmasked bits of `rd_data`, and overwrites clear them. `done` never lasts two cycles, and a start during a run leaves the captured base unchanged. Only the bench's scenarios can show the rest. That covers the exact written values for mixed source and predicate patterns, which elements are skipped with no write, and inversion and wrap-around. It also covers the run length from start to `done`, including the empty and over-long cases.

// File: rtl/pvec_pkg.sv
package pvec_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } pvec_state_e;

    // Per-bit result for one active element with source bit s.
    function automatic logic [3:0] elem_value(
        input logic       s,
        input logic [3:0] msk,
        input logic [3:0] mde
    );
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            r[k] = msk[k] & (mde[k] == s);
        end
        return r;
    endfunction

endpackage

// File: rtl/pvec_pred_sel.sv
module pvec_pred_sel #(
    parameter int CNT_W = 4
) (
    input  logic [63:0]      pred,
    input  logic             pred_inv,
    input  logic [63:0]      src,
    input  logic             src_zero,
    input  logic [CNT_W-1:0] elem,
    output logic             pbit,
    output logic             sbit
);
    always_comb begin
        pbit = pred[elem] ^ pred_inv;
        sbit = src_zero ? 1'b0 : src[elem];
    end
endmodule

// File: rtl/pvec_field_calc.sv
module pvec_field_calc
    import pvec_pkg::*;
(
    input  logic       pbit,
    input  logic       sbit,
    input  logic [3:0] mask,
    input  logic [3:0] mode,
    input  logic       merge,
    input  logic [3:0] old_val,
    output logic [3:0] data
);
    logic [3:0] core;
    always_comb begin
        core = elem_value(sbit, mask, mode);
        if (!pbit) begin
            data = 4'b0000;
        end else if (merge) begin
            data = core | (old_val & ~mask);
        end else begin
            data = core;
        end
    end
endmodule

// File: rtl/pvec_field_writer.sv
module pvec_field_writer
    import pvec_pkg::*;
#(
    parameter int NUM_FIELDS = 16,
    parameter int MAX_VL     = 16,
    parameter int IDX_W      = $clog2(NUM_FIELDS),
    parameter int VL_W       = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [VL_W-1:0]  vlen,
    input  logic [63:0]      pred,
    input  logic             pred_inv,
    input  logic             zero_en,
    input  logic [63:0]      src,
    input  logic             src_zero,
    input  logic [3:0]       mask,
    input  logic [3:0]       mode,
    input  logic             merge,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [3:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [3:0]       wr_data,
    output logic             busy,
    output logic             done
);
    localparam int CNT_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    pvec_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] base_q;
    logic [VL_W-1:0]  vl_q;
    logic [63:0]      pred_q, src_q;
    logic             inv_q, zero_q, srcz_q, merge_q;
    logic [3:0]       mask_q, mode_q;
    logic [VL_W-1:0]  vl_eff;
    logic             pbit, sbit;
    logic             last_elem;

    assign vl_eff    = (vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen;
    assign last_elem = (VL_W'(cnt_q) == vl_q - VL_W'(1));

    pvec_pred_sel #(.CNT_W(CNT_W)) u_sel (
        .pred     (pred_q),
        .pred_inv (inv_q),
        .src      (src_q),
        .src_zero (srcz_q),
        .elem     (cnt_q),
        .pbit     (pbit),
        .sbit     (sbit)
    );

    pvec_field_calc u_calc (
        .pbit    (pbit),
        .sbit    (sbit),
        .mask    (mask_q),
        .mode    (mode_q),
        .merge   (merge_q),
        .old_val (rd_data),
        .data    (wr_data)
    );

    // State register and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            vl_q    <= '0;
            pred_q  <= '0;
            src_q   <= '0;
            inv_q   <= 1'b0;
            zero_q  <= 1'b0;
            srcz_q  <= 1'b0;
            merge_q <= 1'b0;
            mask_q  <= '0;
            mode_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        base_q  <= base_idx;
                        vl_q    <= vl_eff;
                        pred_q  <= pred;
                        src_q   <= src;
                        inv_q   <= pred_inv;
                        zero_q  <= zero_en;
                        srcz_q  <= src_zero;
                        merge_q <= merge;
                        mask_q  <= mask;
                        mode_q  <= mode;
                        state_q <= (vl_eff == '0) ? S_DONE : S_RUN;  // empty / launch
                    end
                end
                S_RUN: begin
                    if (last_elem) begin
                        state_q <= S_DONE;                          // finish
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);                 // step
                    end
                end
                S_DONE:  state_q <= S_IDLE;                         // retire
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en  = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        wr_idx = base_q + IDX_W'(cnt_q);
        rd_idx = wr_idx;
        unique case (state_q)
            S_IDLE: ;
            S_RUN: begin
                busy  = 1'b1;
                wr_en = pbit | zero_q;
            end
            S_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && $past(state_q) == S_RUN) |-> (wr_idx == $past(wr_idx) + IDX_W'(1)));

    p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pbit) |-> (wr_data == 4'b0000));

    p_merge_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pbit && merge_q) |-> ((wr_data & ~mask_q) == (rd_data & ~mask_q)));

    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pbit && !merge_q) |-> ((wr_data & ~mask_q) == 4'b0000));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_q));

endmodule

// File: tb/tb_pvec_field_writer.sv
`timescale 1ns/1ps
module tb_pvec_field_writer;
    localparam int NF    = 16;
    localparam int MVL   = 16;
    localparam int IDX_W = $clog2(NF);
    localparam int VL_W  = $clog2(MVL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] base_idx = '0;
    logic [VL_W-1:0]  vlen = '0;
    logic [63:0]      pred = '0, src = '0;
    logic             pred_inv = 1'b0, zero_en = 1'b0, src_zero = 1'b0, merge = 1'b0;
    logic [3:0]       mask = '0, mode = '0;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [3:0]       rd_data, wr_data;
    logic             wr_en, busy, done;

    logic [3:0] fields [NF];

    typedef struct {
        logic [IDX_W-1:0] idx;
        logic [3:0]       data;
        string            tag;
    } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    assign rd_data = fields[rd_idx];

    pvec_field_writer #(.NUM_FIELDS(NF), .MAX_VL(MVL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx), .vlen(vlen),
        .pred(pred), .pred_inv(pred_inv), .zero_en(zero_en), .src(src),
        .src_zero(src_zero), .mask(mask), .mode(mode), .merge(merge),
        .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    // Field file model (the environment)
    always @(posedge clk) begin
        if (wr_en) fields[wr_idx] <= wr_data;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected writes
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {wr_idx, wr_data}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(wr_idx == e.idx, {e.tag, " R2 index"}, wr_idx, e.idx);
                check(wr_data == e.data, {e.tag, " value"}, wr_data, e.data);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_op(input int b, input int vl, input logic [63:0] p, input logic inv,
                          input logic z, input logic [63:0] s, input logic sz,
                          input logic [3:0] mk, input logic [3:0] md, input logic m,
                          input bit bump, input string tag);
        int         vle;
        int         n;
        logic [3:0] snap [NF];
        bit         touched [NF];
        vle = (vl > MVL) ? MVL : vl;
        for (int k = 0; k < NF; k++) begin
            snap[k] = fields[k];
            touched[k] = 1'b0;
        end
        for (int i = 0; i < vle; i++) begin
            exp_t e;
            logic pb, sb;
            logic [3:0] v;
            pb = p[i] ^ inv;
            sb = sz ? 1'b0 : s[i];
            e.idx = IDX_W'((b + i) % NF);
            e.tag = tag;
            if (pb) begin
                for (int k = 0; k < 4; k++) v[k] = mk[k] & (md[k] == sb);
                if (m) v = v | (fields[e.idx] & ~mk);
                e.data = v;
                exp_q.push_back(e);
                touched[e.idx] = 1'b1;
            end else if (z) begin
                e.data = 4'b0000;
                exp_q.push_back(e);
                touched[e.idx] = 1'b1;
            end
        end
        @(negedge clk);
        base_idx = IDX_W'(b); vlen = VL_W'(vl); pred = p; pred_inv = inv; zero_en = z;
        src = s; src_zero = sz; mask = mk; mode = md; merge = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Change inputs after capture; they must have no effect
        base_idx = ~base_idx; pred = ~pred; src = ~src; mask = ~mask;
        n = 1;
        while (!done && n < 100) begin
            if (bump && n == 2) start = 1'b1;   // R9: start while busy is ignored
            else start = 1'b0;
            check(busy == 1'b1, {tag, " R9 busy"}, busy, 1);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == vle + 1, {tag, " R9/R10/R11 cycles to done"}, n, vle + 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {tag, " R9 done one cycle"}, {done, busy}, 0);
        check(exp_q.size() == 0, {tag, " missing writes"}, exp_q.size(), 0);
        exp_q.delete();
        for (int k = 0; k < NF; k++) begin
            if (!touched[k])
                check(fields[k] == snap[k], {tag, " R4 untouched field"}, fields[k], snap[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < NF; k++) fields[k] = 4'(k * 7 + 3);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wr_en == 1'b0 && done == 1'b0 && busy == 1'b0, "R1 reset idle",
              {wr_en, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 1'b0 && busy == 1'b0, "R1 idle after reset", {wr_en, busy}, 0);

        // R3 R5 R6: zero source, element 0 zeroed, element 1 writes mask&~mode = 0011
        run_op(8, 2, 64'h2, 1'b0, 1'b1, 64'hFFFF, 1'b1, 4'b0011, 4'b0000, 1'b0, 0, "R3/R5/R6");
        check(fields[8] == 4'b0000, "R3 field 8 zeroed", fields[8], 0);
        check(fields[9] == 4'b0011, "R5 field 9 = 0011", fields[9], 4'b0011);

        // R5 R7: mixed source bits, merge on
        run_op(3, 6, 64'h3F, 1'b0, 1'b0, 64'h2D, 1'b0, 4'b0101, 4'b0110, 1'b1, 0, "R5/R7 merge");

        // R4: sparse predicate, no zeroing
        run_op(0, 8, 64'hA5, 1'b0, 1'b0, 64'hF0, 1'b0, 4'b1111, 4'b1010, 1'b0, 0, "R4 skip");

        // R8 R2: inverted predicate with wrap-around, zeroing, merge
        run_op(14, 5, 64'h0B, 1'b1, 1'b1, 64'h15, 1'b0, 4'b1001, 4'b1111, 1'b1, 0, "R8 wrap");

        // R10: empty vector
        run_op(5, 0, 64'hFFFF, 1'b0, 1'b1, 64'h0, 1'b0, 4'b1111, 4'b0000, 1'b0, 0, "R10 empty");

        // R11 R9: over-long vector clamps, start while busy ignored
        run_op(2, 20, 64'hFFFF_FFFF, 1'b0, 1'b0, 64'hC3A5, 1'b0, 4'b1110, 4'b0100, 1'b0, 1, "R11 clamp");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule